// File: doc/BRIEF.md
# Multi-Channel DMA Termination Controller

This block runs the start, byte counting and termination of each channel of a small bus-master DMA engine. Software starts a channel by writing its start bit together with a byte count. The bus engine reports each finished four-byte beat on the channel's acknowledge input. The channel then counts the remaining bytes down and stops once the count is used up. That is a normal end.

A channel can also end early. This happens when its bus-error input fires, or when software writes its stop bit. That is an abnormal end. On an abnormal end an end-status flag rises at once, and the channel stays active until any beat still in flight has finished. Every termination sets a sticky completion flag, whatever the mask. A channel raises an interrupt only when that flag is set and its enable is set. The per-channel interrupts are merged into one registered line.

A fault or a stop on one channel leaves the other channels untouched.

Top module: `dma_term_ctrl`

## Requirements
- R1: After reset, every output is 0. An accepted start with a nonzero count makes `xfer_active` go high after one clock edge and clears that channel's `abn_end`.
- R2: Each `beat_ack` seen while a channel runs lowers its remaining count by 4. The beat that finds 4 or fewer bytes left ends the transfer normally: `xfer_active` falls and `done_flag` rises on the same edge, with `abn_end` 0.
- R3: A start with a byte count of 0 never raises `xfer_active`. It sets `done_flag` after one edge, with `abn_end` 0.
- R4: A write with the stop bit set on a running channel sets `abn_end` on the next edge while `xfer_active` stays high. The channel ends on the first later edge where `beat_pend` is low or `beat_ack` is high. There `xfer_active` falls and `done_flag` rises.
- R5: `bus_err` on a running channel ends it abnormally, in the same way as R4. All other channels keep running and counting unaffected.
- R6: `done_flag` is set on every termination whatever the interrupt enable. It stays set until a write with the clear bit set removes it. A termination in the same cycle as a clear leaves it set.
- R7: A start write is ignored while the channel is active, or while its `done_flag` is still set. An ignored start does not reload the count.
- R8: `irq` is the registered OR over all channels of `done_flag` AND the interrupt enable. It follows a change of either one a single edge later.
- R9: A stop write or a `bus_err` on an idle channel has no effect on any of its outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | NCH | Per-channel control write strobe |
| cfg_start | input | NCH | Start bit of the write |
| cfg_stop | input | NCH | Forced-stop bit of the write |
| cfg_irq_en | input | NCH | Interrupt enable, loaded on every write |
| cfg_clr_done | input | NCH | Write 1 to clear the completion flag |
| cfg_bytes | input | NCH*CNT_W | Byte count per channel, taken on an accepted start |
| beat_ack | input | NCH | One beat (4 bytes) finished on the bus |
| beat_pend | input | NCH | A beat is issued and not yet finished |
| bus_err | input | NCH | Bus error seen on the channel |
| xfer_active | output | NCH | Channel transfer in progress |
| abn_end | output | NCH | Most recent end was abnormal |
| done_flag | output | NCH | Sticky completion status |
| irq | output | 1 | Combined interrupt |

## Verification
A miscounted byte counter shows up as `xfer_active` falling one beat early or late. This is visible on the edge of the final acknowledge. A drain state that does not wait for the in-flight beat ends a stopped channel one or more edges too soon. A drain state that waits too long keeps the channel active after `beat_pend` drops. Fault leakage between channels shows as a neighbour's `xfer_active` or `abn_end` changing on the same edge as the faulting channel. Interrupt gating errors appear on `irq` exactly one edge after `done_flag` or the enable changes.

// File: rtl/dma_term_pkg.sv
package dma_term_pkg;
  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_RUN   = 2'd1,
    CH_DRAIN = 2'd2
  } ch_state_e;
endpackage

// File: rtl/dma_term_chan.sv
module dma_term_chan
  import dma_term_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int BEAT_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             wr_start,
  input  logic             wr_stop,
  input  logic             wr_irq_en,
  input  logic             wr_clr,
  input  logic [CNT_W-1:0] wr_bytes,
  input  logic             ack,
  input  logic             pend,
  input  logic             err,
  output logic             active,
  output logic             abn,
  output logic             done,
  output logic             irq_en
);
  localparam logic [CNT_W-1:0] BEAT_L = CNT_W'(BEAT_BYTES);

  ch_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             end_q, end_d;
  logic             done_q, done_d;
  logic             en_q, en_d;
  logic             term;
  logic             cnt_en;

  // next-state logic
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    end_d  = end_q;
    en_d   = wr ? wr_irq_en : en_q;
    term   = 1'b0;
    cnt_en = 1'b0;
    unique case (st_q)
      CH_IDLE: begin
        if (wr && wr_start && !done_q) begin
          end_d = 1'b0;
          if (wr_bytes == '0) begin
            term = 1'b1;
          end else begin
            st_d   = CH_RUN;
            cnt_d  = wr_bytes;
            cnt_en = 1'b1;
          end
        end
      end
      CH_RUN: begin
        if (err || (wr && wr_stop)) begin
          end_d = 1'b1;
          st_d  = CH_DRAIN;
        end else if (ack) begin
          cnt_en = 1'b1;
          if (cnt_q <= BEAT_L) begin
            term  = 1'b1;
            st_d  = CH_IDLE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q - BEAT_L;
          end
        end
      end
      CH_DRAIN: begin
        if (!pend || ack) begin
          term = 1'b1;
          st_d = CH_IDLE;
        end
      end
      default: st_d = CH_IDLE;
    endcase
    if (term)               done_d = 1'b1;
    else if (wr && wr_clr)  done_d = 1'b0;
    else                    done_d = done_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CH_IDLE;
      cnt_q  <= '0;
      end_q  <= 1'b0;
      done_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      end_q  <= end_d;
      done_q <= done_d;
      en_q   <= en_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign active = (st_q != CH_IDLE);
  assign abn    = end_q;
  assign done   = done_q;
  assign irq_en = en_q;

  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !(wr && wr_clr) |=> done_q);
  assert_abn_while_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_q) |-> active);
  assert_end_sets_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> done_q);
  assert_start_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !active && !(wr && wr_clr) |=> !active);
  assert_idle_no_abn_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active && !(wr && wr_start) |=> $stable(end_q));
endmodule

// File: rtl/dma_irq_merge.sv
module dma_irq_merge #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] done,
  input  logic [NCH-1:0] irq_en,
  output logic           irq
);
  logic irq_q, irq_d;

  always_comb irq_d = |(done & irq_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(done & irq_en)) |=> !irq_q);
  assert_irq_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(done & irq_en)) |=> irq_q);
endmodule

// File: rtl/dma_term_ctrl.sv
module dma_term_ctrl #(
  parameter int NCH        = 4,
  parameter int CNT_W      = 16,
  parameter int BEAT_BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       cfg_wr,
  input  logic [NCH-1:0]       cfg_start,
  input  logic [NCH-1:0]       cfg_stop,
  input  logic [NCH-1:0]       cfg_irq_en,
  input  logic [NCH-1:0]       cfg_clr_done,
  input  logic [NCH*CNT_W-1:0] cfg_bytes,
  input  logic [NCH-1:0]       beat_ack,
  input  logic [NCH-1:0]       beat_pend,
  input  logic [NCH-1:0]       bus_err,
  output logic [NCH-1:0]       xfer_active,
  output logic [NCH-1:0]       abn_end,
  output logic [NCH-1:0]       done_flag,
  output logic                 irq
);
  logic [NCH-1:0] en_vec;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma_term_chan #(
      .CNT_W     (CNT_W),
      .BEAT_BYTES(BEAT_BYTES)
    ) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (cfg_wr[c]),
      .wr_start (cfg_start[c]),
      .wr_stop  (cfg_stop[c]),
      .wr_irq_en(cfg_irq_en[c]),
      .wr_clr   (cfg_clr_done[c]),
      .wr_bytes (cfg_bytes[c*CNT_W +: CNT_W]),
      .ack      (beat_ack[c]),
      .pend     (beat_pend[c]),
      .err      (bus_err[c]),
      .active   (xfer_active[c]),
      .abn      (abn_end[c]),
      .done     (done_flag[c]),
      .irq_en   (en_vec[c])
    );
  end

  dma_irq_merge #(.NCH(NCH)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .done  (done_flag),
    .irq_en(en_vec),
    .irq   (irq)
  );
endmodule

// File: tb/tb_dma_term_ctrl.sv
module tb_dma_term_ctrl;
  localparam int NCH = 4;
  localparam int CW  = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0] wr, st, sp, en, cl, ack, pend, err;
  logic [NCH*CW-1:0] bytes;
  logic [NCH-1:0] act, abn, dn;
  logic irq;

  int tests = 0;
  int fails = 0;

  int m_st[NCH];
  int m_cnt[NCH];
  bit m_end[NCH], m_done[NCH], m_en[NCH];
  bit m_irq;

  always #10 clk = ~clk;

  dma_term_ctrl #(.NCH(NCH), .CNT_W(CW), .BEAT_BYTES(4)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(wr), .cfg_start(st), .cfg_stop(sp),
    .cfg_irq_en(en), .cfg_clr_done(cl), .cfg_bytes(bytes), .beat_ack(ack),
    .beat_pend(pend), .bus_err(err), .xfer_active(act), .abn_end(abn),
    .done_flag(dn), .irq(irq)
  );

  task automatic chk(input string tag, input int a, input int e);
    tests++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, a, e);
    end
  endtask

  function automatic int bytes_of(input int c);
    return int'(bytes[c*CW +: CW]);
  endfunction

  // reference model, one clock edge
  task automatic model_edge();
    int  n_st[NCH];
    int  n_cnt[NCH];
    bit  n_end[NCH], n_done[NCH], n_en[NCH];
    bit  n_irq;
    n_irq = 1'b0;
    for (int c = 0; c < NCH; c++) n_irq |= m_done[c] & m_en[c];
    for (int c = 0; c < NCH; c++) begin
      bit term;
      term = 1'b0;
      n_st[c] = m_st[c]; n_cnt[c] = m_cnt[c]; n_end[c] = m_end[c];
      n_en[c] = wr[c] ? en[c] : m_en[c];
      if (m_st[c] == 0) begin
        if (wr[c] && st[c] && !m_done[c]) begin
          n_end[c] = 1'b0;
          if (bytes_of(c) == 0) term = 1'b1;
          else begin n_st[c] = 1; n_cnt[c] = bytes_of(c); end
        end
      end else if (m_st[c] == 1) begin
        if (err[c] || (wr[c] && sp[c])) begin n_end[c] = 1'b1; n_st[c] = 2; end
        else if (ack[c]) begin
          if (m_cnt[c] <= 4) begin term = 1'b1; n_st[c] = 0; n_cnt[c] = 0; end
          else n_cnt[c] = m_cnt[c] - 4;
        end
      end else begin
        if (!pend[c] || ack[c]) begin term = 1'b1; n_st[c] = 0; end
      end
      if (term) n_done[c] = 1'b1;
      else if (wr[c] && cl[c]) n_done[c] = 1'b0;
      else n_done[c] = m_done[c];
    end
    for (int c = 0; c < NCH; c++) begin
      m_st[c] = n_st[c]; m_cnt[c] = n_cnt[c]; m_end[c] = n_end[c];
      m_done[c] = n_done[c]; m_en[c] = n_en[c];
    end
    m_irq = n_irq;
  endtask

  task automatic cycle();
    @(posedge clk);
    model_edge();
    #1;
    for (int c = 0; c < NCH; c++) begin
      chk("R1 active vs model", int'(act[c]), int'(m_st[c] != 0));
      chk("R4 abn_end vs model", int'(abn[c]), int'(m_end[c]));
      chk("R6 done vs model", int'(dn[c]), int'(m_done[c]));
    end
    chk("R8 irq vs model", int'(irq), int'(m_irq));
  endtask

  task automatic quiet();
    wr = '0; st = '0; sp = '0; cl = '0; ack = '0; err = '0;
  endtask

  task automatic cwrite(input int c, input bit s, input bit p, input bit e,
                        input bit k, input int b);
    wr[c] = 1'b1; st[c] = s; sp[c] = p; en[c] = e; cl[c] = k;
    bytes[c*CW +: CW] = CW'(b);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    rst_n = 1'b0; quiet(); en = '0; pend = '0; bytes = '0;
    for (int c = 0; c < NCH; c++) begin
      m_st[c] = 0; m_cnt[c] = 0; m_end[c] = 0; m_done[c] = 0; m_en[c] = 0;
    end
    m_irq = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset active", int'(act), 0);
    chk("R1 reset abn", int'(abn), 0);
    chk("R1 reset done", int'(dn), 0);
    chk("R1 reset irq", int'(irq), 0);
    rst_n = 1'b1;

    // R1/R2 normal end after three beats
    cwrite(0, 1, 0, 1, 0, 12); cycle(); quiet();
    chk("R1 start active", int'(act[0]), 1);
    ack[0] = 1'b1; cycle(); cycle();
    chk("R2 still running after 2 beats", int'(act[0]), 1);
    cycle();
    chk("R2 normal end active", int'(act[0]), 0);
    chk("R2 normal end done", int'(dn[0]), 1);
    chk("R2 normal end abn", int'(abn[0]), 0);
    quiet(); cycle();
    chk("R8 irq raised", int'(irq), 1);

    // R6/R8 clear
    cwrite(0, 0, 0, 1, 1, 0); cycle(); quiet();
    chk("R6 cleared", int'(dn[0]), 0);
    cycle();
    chk("R8 irq dropped", int'(irq), 0);

    // R3 zero count, mask off
    cwrite(0, 1, 0, 0, 0, 0); cycle(); quiet();
    chk("R3 zero count done", int'(dn[0]), 1);
    chk("R3 zero count no active", int'(act[0]), 0);
    cycle();
    chk("R8 masked irq", int'(irq), 0);

    // R7 start while done set
    cwrite(0, 1, 0, 1, 0, 20); cycle(); quiet();
    chk("R7 start ignored while done", int'(act[0]), 0);
    cwrite(0, 0, 0, 1, 1, 0); cycle(); quiet();

    // R5 bus error on channel 1, channel 0 unaffected
    cwrite(0, 1, 0, 1, 0, 40); cwrite(1, 1, 0, 1, 0, 40); cycle(); quiet();
    err[1] = 1'b1; pend[1] = 1'b1; cycle(); err = '0;
    chk("R5 abn set", int'(abn[1]), 1);
    chk("R5 still draining", int'(act[1]), 1);
    chk("R5 neighbour running", int'(act[0]), 1);
    chk("R5 neighbour abn", int'(abn[0]), 0);
    cycle();
    chk("R5 waits for beat", int'(act[1]), 1);
    pend[1] = 1'b0; cycle();
    chk("R5 ended", int'(act[1]), 0);
    chk("R5 done", int'(dn[1]), 1);
    chk("R5 neighbour still running", int'(act[0]), 1);

    // R4 forced stop on channel 0
    cwrite(0, 0, 1, 1, 0, 40); pend[0] = 1'b1; cycle(); quiet();
    chk("R4 abn on stop", int'(abn[0]), 1);
    chk("R4 active during drain", int'(act[0]), 1);
    ack[0] = 1'b1; cycle(); quiet(); pend[0] = 1'b0;
    chk("R4 ended", int'(act[0]), 0);
    chk("R4 done", int'(dn[0]), 1);
    cwrite(0, 0, 0, 1, 1, 0); cwrite(1, 0, 0, 1, 1, 0); cycle(); quiet();

    // R6 termination beats clear
    cwrite(2, 1, 0, 0, 0, 4); cycle(); quiet();
    ack[2] = 1'b1; cwrite(2, 0, 0, 0, 1, 0); cycle(); quiet();
    chk("R6 termination wins", int'(dn[2]), 1);
    cwrite(2, 0, 0, 0, 1, 0); cycle(); quiet();

    // R9 stop and error on idle channel
    cwrite(3, 0, 1, 0, 0, 0); err[3] = 1'b1; cycle(); quiet();
    chk("R9 idle abn", int'(abn[3]), 0);
    chk("R9 idle done", int'(dn[3]), 0);
    chk("R9 idle active", int'(act[3]), 0);

    // R7 restart while active does not reload
    cwrite(3, 1, 0, 0, 0, 8); cycle(); quiet();
    ack[3] = 1'b1; cycle(); quiet();
    cwrite(3, 1, 0, 0, 0, 40); cycle(); quiet();
    ack[3] = 1'b1; cycle(); quiet();
    chk("R7 no reload", int'(act[3]), 0);
    chk("R7 ends on old count", int'(dn[3]), 1);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      quiet();
      for (int c = 0; c < NCH; c++) begin
        if ($urandom_range(7) == 0) begin
          wr[c] = 1'b1;
          st[c] = ($urandom_range(1) == 0);
          sp[c] = ($urandom_range(3) == 0);
          en[c] = ($urandom_range(2) != 0);
          cl[c] = ($urandom_range(2) == 0);
          bytes[c*CW +: CW] = CW'($urandom_range(40));
        end
        ack[c]  = ($urandom_range(1) == 0);
        pend[c] = ($urandom_range(1) == 0);
        err[c]  = ($urandom_range(39) == 0);
      end
      cycle();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule